// File: doc/BRIEF.md
# Receive Cell Buffer for an 8-bit ATM Cell Interface

This block is the receive half of the PHY side of an 8-bit cell interface. The line side writes cell bytes into it one at a time. It frames them into 53-byte cells by count and holds up to two cells in a two-slot store. An external ATM-layer device reads the bytes back in order by asserting a read enable on the shared clock.

Three flags guide the reader. A start-of-cell flag travels with the first byte of every cell. A cell-available flag says that at least one whole cell is waiting to be started. An empty flag says that one more read would underflow. A read attempted while the empty flag is up is dropped and latches a sticky error bit. A cell that arrives with both slots taken is thrown away whole, and a saturating counter records the drop.

Top module: `utopia_rx_cellbuf`

## Requirements
- R1: After reset, rd_empty is 1 and rd_clav, rd_soc, rd_data, rd_underflow and ovf_count are all 0.
- R2: Each accepted read (rd_en high while rd_empty is low at a rising edge) puts the next buffered byte on rd_data one cycle later. Bytes come out in the order they were written, cell after cell.
- R3: rd_soc is 1 in the cycle after the read that returns the first byte of a cell, and 0 after every other accepted read.
- R4: rd_empty is 1 exactly when no byte of a complete cell remains unread.
- R5: rd_clav is 1 when at least one complete cell is buffered and none of its bytes has been read yet.
- R6: The line side frames cells by count. A cell becomes readable only after its 53rd byte is written, so rd_empty stays 1 while a first cell is partly written.
- R7: A read with rd_en high while rd_empty is 1 changes neither rd_data nor rd_soc. It sets rd_underflow, which stays 1 until reset.
- R8: A cell holds a slot from the write of its first byte until the read of its last byte. If a cell's first byte arrives while both slots are held, all 53 of its bytes are discarded and ovf_count rises by one, saturating at its maximum.
- R9: When rd_en is low, rd_data and rd_soc keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Line-side byte write strobe |
| wr_data | input | DATA_W | Line-side byte |
| rd_en | input | 1 | Read enable from the ATM-layer device |
| rd_data | output | DATA_W | Registered output byte |
| rd_soc | output | 1 | Registered start-of-cell marker |
| rd_empty | output | 1 | A further read would underflow |
| rd_clav | output | 1 | A whole unstarted cell is available |
| rd_underflow | output | 1 | Sticky error: read attempted while empty |
| ovf_count | output | OVF_W | Saturating count of discarded cells |

## Verification
Several patterns are run against a behavioural queue model that is compared every clock. Reads into an empty buffer separate a design that ignores the read from one that returns stale data. A half-written first cell shows whether the empty flag waits for the last byte. Three back-to-back cells with no reads fill both slots and force a discard of the third. Writes and reads in the same cycles, with a random rd_en pattern, test slot release and start-of-cell placement at cell boundaries and the cell-available flag during a partly read cell.

// File: rtl/utopia_rx_cellbuf.sv
module utopia_rx_cellbuf #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int OVF_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_soc,
  output logic              rd_empty,
  output logic              rd_clav,
  output logic              rd_underflow,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int DEPTH  = 2 * CELL_BYTES;
  localparam int IDX_W  = $clog2(CELL_BYTES);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_slot, rd_slot, wr_drop;
  logic [1:0]        occ, done;

  wire wr_first = wr_valid && (wr_idx == '0);
  wire drop_now = wr_first ? (occ == 2'd2) : wr_drop;
  wire wr_last  = wr_valid && (wr_idx == LAST);
  wire store    = wr_valid && !drop_now;
  wire commit   = wr_last && !drop_now;
  wire rd_ok    = rd_en && (done != 2'd0);
  wire rd_last  = rd_ok && (rd_idx == LAST);

  wire [ADDR_W-1:0] wr_addr = wr_slot ? ADDR_W'(CELL_BYTES) + ADDR_W'(wr_idx) : ADDR_W'(wr_idx);
  wire [ADDR_W-1:0] rd_addr = rd_slot ? ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx) : ADDR_W'(rd_idx);

  assign rd_empty = (done == 2'd0);
  assign rd_clav  = (done > 2'd1) || (done == 2'd1 && rd_idx == '0);

  always_ff @(posedge clk)
    if (store) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0; wr_slot <= 1'b0; wr_drop <= 1'b0;
      rd_idx <= '0; rd_slot <= 1'b0;
      occ <= 2'd0; done <= 2'd0;
      rd_data <= '0; rd_soc <= 1'b0;
      rd_underflow <= 1'b0; ovf_count <= '0;
    end else begin
      if (wr_valid) begin
        wr_idx  <= wr_last ? '0 : wr_idx + 1'b1;
        wr_drop <= drop_now;
      end
      if (commit) wr_slot <= ~wr_slot;
      if (wr_first && drop_now && ovf_count != '1) ovf_count <= ovf_count + 1'b1;
      occ  <= occ + {1'b0, wr_first && !drop_now} - {1'b0, rd_last};
      done <= done + {1'b0, commit} - {1'b0, rd_last};
      if (rd_ok) begin
        rd_data <= mem[rd_addr];
        rd_soc  <= (rd_idx == '0);
        rd_idx  <= rd_last ? '0 : rd_idx + 1'b1;
        if (rd_last) rd_slot <= ~rd_slot;
      end
      if (rd_en && rd_empty) rd_underflow <= 1'b1;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 2'd2 && done <= occ); // R8
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_empty |=> $stable(rd_data) && $stable(rd_soc) && rd_underflow); // R7
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_underflow |=> rd_underflow); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data) && $stable(rd_soc)); // R9
  AST_CLAV_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clav |-> !rd_empty); // R5
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_idx == '0 && occ == 2'd2 && ovf_count != '1 |=> ovf_count == $past(ovf_count) + 1'b1); // R8
endmodule

// File: tb/tb_utopia_rx_cellbuf.sv
module tb_utopia_rx_cellbuf;
  localparam int CB = 53;
  logic clk = 0, rst_n = 0, wr_valid = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_soc, rd_empty, rd_clav, rd_underflow;
  logic [7:0] ovf_count;
  int checks = 0, errors = 0;

  utopia_rx_cellbuf dut (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_soc(rd_soc), .rd_empty(rd_empty),
    .rd_clav(rd_clav), .rd_underflow(rd_underflow), .ovf_count(ovf_count));

  always #2.5 clk = ~clk;

  byte unsigned ready_q[$], cur_q[$];
  int m_cells = 0, m_occ = 0, m_rdpos = 0, m_wpos = 0, m_ovf = 0;
  bit m_drop = 0, m_uf = 0, m_soc = 0;
  byte unsigned m_data = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ready_q.delete(); cur_q.delete();
      m_cells = 0; m_occ = 0; m_rdpos = 0; m_wpos = 0; m_ovf = 0;
      m_drop = 0; m_uf = 0; m_soc = 0; m_data = 0;
    end else begin
      int occ0;
      occ0 = m_occ;
      if (rd_en) begin
        if (m_cells == 0) m_uf = 1;
        else begin
          m_data = ready_q.pop_front();
          m_soc = (m_rdpos == 0);
          m_rdpos++;
          if (m_rdpos == CB) begin m_rdpos = 0; m_cells--; m_occ--; end
        end
      end
      if (wr_valid) begin
        if (m_wpos == 0) begin
          m_drop = (occ0 == 2);
          if (m_drop) begin if (m_ovf < 255) m_ovf++; end
          else m_occ++;
        end
        if (!m_drop) cur_q.push_back(wr_data);
        m_wpos++;
        if (m_wpos == CB) begin
          m_wpos = 0;
          if (!m_drop) begin
            foreach (cur_q[i]) ready_q.push_back(cur_q[i]);
            m_cells++;
          end
          cur_q.delete();
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(rd_data == m_data, "R2 R9 data", rd_data, m_data);
    chk(rd_soc == m_soc, "R3 soc", rd_soc, m_soc);
    chk(rd_empty == (m_cells == 0), "R4 empty", rd_empty, m_cells == 0);
    chk(rd_clav == (m_cells > 1 || (m_cells == 1 && m_rdpos == 0)), "R5 clav", rd_clav,
        m_cells > 1 || (m_cells == 1 && m_rdpos == 0));
    chk(rd_underflow == m_uf, "R7 underflow", rd_underflow, m_uf);
    chk(ovf_count == m_ovf, "R8 ovf", ovf_count, m_ovf);
  end

  task automatic put_bytes(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = 8'(base + i);
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rd_empty && !rd_clav && !rd_soc && rd_data == 0 && !rd_underflow && ovf_count == 0,
        "R1 reset", {rd_empty, rd_clav, rd_soc, rd_underflow}, 4'b1000);
    // R7: reads while empty
    rd_en = 1; idle(2); rd_en = 0; idle(1);
    chk(rd_underflow == 1, "R7 sticky set", rd_underflow, 1);
    // R6: partial first cell is not readable
    put_bytes(8'h10, CB - 1);
    chk(rd_empty == 1, "R6 partial cell empty", rd_empty, 1);
    put_bytes(8'h10 + CB - 1, 1);
    chk(rd_empty == 0 && rd_clav == 1, "R6 complete cell", {rd_empty, rd_clav}, 2'b01);
    // R2 R3: read whole cell with gaps
    for (int i = 0; i < CB; i++) begin
      rd_en = 1; @(negedge clk); rd_en = (i % 3 == 0); if (rd_en && i < CB - 1) begin @(negedge clk); i++; end
      rd_en = 0; @(negedge clk);
    end
    idle(3);
    // R8: three cells without reads, third dropped
    put_bytes(8'h40, CB); put_bytes(8'h80, CB); put_bytes(8'hC0, CB);
    chk(ovf_count == 1, "R8 third cell dropped", ovf_count, 1);
    // drain with reads overlapping a new write
    fork
      begin rd_en = 1; repeat (2 * CB + 5) @(negedge clk); rd_en = 0; end
      begin idle(CB - 2); put_bytes(8'h05, CB); end
    join
    idle(2);
    // random read enables while cells stream in
    fork
      begin
        repeat (800) begin rd_en = ($urandom % 3) != 0; @(negedge clk); end
        rd_en = 0;
      end
      begin
        for (int c = 0; c < 8; c++) begin put_bytes(c * 29, CB); idle($urandom % 40); end
      end
    join
    rd_en = 1; idle(3 * CB); rd_en = 0; idle(2);
    chk(rd_empty == 1 && rd_underflow == 1, "R4 R7 drained", {rd_empty, rd_underflow}, 2'b11);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule